// File: doc/BRIEF.md
# Raster Dot and Line Timing Generator

This block produces the raster timing skeleton for a video generator. A dot counter runs across each line and a line counter steps down the frame on a grid of 341 dots by 262 lines. Alongside the position it keeps a running frame count and an odd/even frame flag. It also classifies the current line into one of four regions.

The generator raises the vertical-blank status flag and a one-cycle NMI request when the blank period starts, and lowers the flag on the pre-render line. On every line that fetches sprites it drives a strobe that forces the sprite-memory address to zero. When rendering is enabled, odd frames drop one dot so that the frame cadence alternates between two lengths.

All outputs are registered and describe the same dot: the flag, the strobes and the region all belong to the position shown on `dot` and `line` in that cycle. The `render_en` and `nmi_en` inputs are sampled on the clock edge that moves the counters into the position they affect.

Top module: `raster_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the outputs are `dot`=0, `line`=0, `odd_frame`=0, `frame_cnt`=0, `vblank`=0, `nmi_pulse`=0 and `oam_clr`=0.
- R2: `dot` counts 0,1,…,340 and then returns to 0. When it returns to 0, `line` advances by one.
- R3: `line` counts 0 to 261 and then returns to 0. Each return to line 0 toggles `odd_frame` and adds one to `frame_cnt`.
- R4: If `render_en` is 1 and `odd_frame` is 1 at line 261, dot 339, the next position is line 0, dot 0. Otherwise dot 340 of line 261 is produced.
- R5: `vblank` becomes 1 at line 241, dot 1. It stays 1 through line 261, dot 0, and becomes 0 at line 261, dot 1.
- R6: `nmi_pulse` is 1 for exactly the one cycle at line 241, dot 1, and only when `nmi_en` was 1 on the edge that entered that dot. `vblank` is set whatever the value of `nmi_en`.
- R7: `oam_clr` is 1 exactly when `dot` is between 257 and 320 inclusive and `line` is either 0 to 239 or 261.
- R8: `region` encodes the line as follows: 0 for lines 0–239 (visible), 1 for line 240 (post-render), 2 for lines 241–260 (vertical blank), and 3 for line 261 (pre-render).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one dot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| render_en | input | 1 | Background or sprite rendering enabled; allows the odd-frame dot skip |
| nmi_en | input | 1 | Allows the NMI pulse at the start of vertical blank |
| dot | output | 9 | Current dot within the line |
| line | output | 9 | Current line within the frame |
| odd_frame | output | 1 | 1 during odd frames |
| frame_cnt | output | 16 | Number of completed frames, wrapping |
| region | output | 2 | Line region code (see R8) |
| vblank | output | 1 | Vertical-blank status flag |
| nmi_pulse | output | 1 | One-cycle NMI request |
| oam_clr | output | 1 | Forces the sprite-memory address to zero |

## Verification
The odd-frame dot skip and the frame wrap happen on the same edge. At line 261, dot 339, one decision ends the line early, ends the frame, toggles the parity and advances the frame count. The bench holds `render_en` high across that point in both an even and an odd frame, so it sees the full dot 340 once and the skip once, and it randomizes `render_en` everywhere else. Each cycle it compares all outputs against a reference model that steps the same counters from the requirements. A wrong parity at the wrap, or a skip taken in the wrong frame, shows up as a mismatch in `dot`, `line`, `odd_frame` and `frame_cnt` on the following cycle.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic [1:0] {
    RGN_VISIBLE = 2'd0,
    RGN_POST    = 2'd1,
    RGN_VBLANK  = 2'd2,
    RGN_PRE     = 2'd3
  } region_t;
endpackage

// File: rtl/raster_pos_counter.sv
module raster_pos_counter #(
  parameter int DOTS    = 341,
  parameter int LINES   = 262,
  parameter int FRAME_W = 16,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              skip_en,
  output logic [DOT_W-1:0]  dot_q,
  output logic [LINE_W-1:0] line_q,
  output logic              odd_q,
  output logic [FRAME_W-1:0] frame_q,
  output logic [DOT_W-1:0]  nxt_dot,
  output logic [LINE_W-1:0] nxt_line
);
  localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS - 1);
  localparam logic [DOT_W-1:0]  SKIP_DOT  = DOT_W'(DOTS - 2);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

  logic short_line, line_end, frame_end;

  always_comb begin
    short_line = skip_en && odd_q && (line_q == LAST_LINE) && (dot_q == SKIP_DOT);
    line_end   = (dot_q == LAST_DOT) || short_line;
    frame_end  = line_end && (line_q == LAST_LINE);
    nxt_dot    = line_end ? '0 : dot_q + 1'b1;
    if (!line_end)      nxt_line = line_q;
    else if (frame_end) nxt_line = '0;
    else                nxt_line = line_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dot_q   <= '0;
      line_q  <= '0;
      odd_q   <= 1'b0;
      frame_q <= '0;
    end else begin
      dot_q  <= nxt_dot;
      line_q <= nxt_line;
      if (frame_end) begin
        odd_q   <= ~odd_q;
        frame_q <= frame_q + 1'b1;
      end
    end
  end

  // R2: dot never leaves the line
  a_r2_dot_bound: assert property (@(posedge clk) disable iff (rst)
    dot_q <= LAST_DOT);
  // R3: parity flips whenever a new frame begins
  a_r3_parity_flip: assert property (@(posedge clk) disable iff (rst)
    (line_q == '0 && dot_q == '0 && $past(line_q) == LAST_LINE) |-> (odd_q != $past(odd_q)));
  // R4: shortened pre-render line on odd rendered frames
  a_r4_odd_skip: assert property (@(posedge clk) disable iff (rst)
    (skip_en && odd_q && line_q == LAST_LINE && dot_q == SKIP_DOT) |=> (dot_q == '0 && line_q == '0));
endmodule

// File: rtl/raster_region.sv
module raster_region
  import raster_pkg::*;
#(
  parameter int LINES     = 262,
  parameter int VIS_LINES = 240,
  parameter int VBL_LINE  = 241,
  localparam int LINE_W   = $clog2(LINES)
) (
  input  logic [LINE_W-1:0] line_i,
  output region_t           region_o
);
  localparam logic [LINE_W-1:0] VIS_END   = LINE_W'(VIS_LINES);
  localparam logic [LINE_W-1:0] VBL_START = LINE_W'(VBL_LINE);
  localparam logic [LINE_W-1:0] PRE_LINE  = LINE_W'(LINES - 1);

  always_comb begin
    if (line_i < VIS_END)        region_o = RGN_VISIBLE;
    else if (line_i == PRE_LINE) region_o = RGN_PRE;
    else if (line_i < VBL_START) region_o = RGN_POST;
    else                         region_o = RGN_VBLANK;
  end
endmodule

// File: rtl/raster_events.sv
module raster_events
  import raster_pkg::*;
#(
  parameter int DOTS     = 341,
  parameter int LINES    = 262,
  parameter int VBL_LINE = 241,
  parameter int FLAG_DOT = 1,
  parameter int OAM_LO   = 257,
  parameter int OAM_HI   = 320,
  localparam int DOT_W   = $clog2(DOTS),
  localparam int LINE_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_en,
  input  logic [DOT_W-1:0]  nxt_dot,
  input  logic [LINE_W-1:0] nxt_line,
  input  region_t           nxt_region,
  input  logic [DOT_W-1:0]  dot_q,
  input  logic [LINE_W-1:0] line_q,
  output region_t           region_q,
  output logic              vblank_q,
  output logic              nmi_q,
  output logic              oam_clr_q
);
  localparam logic [DOT_W-1:0]  F_DOT  = DOT_W'(FLAG_DOT);
  localparam logic [DOT_W-1:0]  W_LO   = DOT_W'(OAM_LO);
  localparam logic [DOT_W-1:0]  W_HI   = DOT_W'(OAM_HI);
  localparam logic [LINE_W-1:0] SET_LN = LINE_W'(VBL_LINE);
  localparam logic [LINE_W-1:0] PRE_LN = LINE_W'(LINES - 1);

  logic set_hit, clr_hit, win_hit;

  always_comb begin
    set_hit = (nxt_line == SET_LN) && (nxt_dot == F_DOT);
    clr_hit = (nxt_line == PRE_LN) && (nxt_dot == F_DOT);
    win_hit = ((nxt_region == RGN_VISIBLE) || (nxt_region == RGN_PRE)) &&
              (nxt_dot >= W_LO) && (nxt_dot <= W_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      region_q  <= RGN_VISIBLE;
      vblank_q  <= 1'b0;
      nmi_q     <= 1'b0;
      oam_clr_q <= 1'b0;
    end else begin
      region_q  <= nxt_region;
      nmi_q     <= set_hit && nmi_en;
      oam_clr_q <= win_hit;
      if (set_hit)      vblank_q <= 1'b1;
      else if (clr_hit) vblank_q <= 1'b0;
    end
  end

  // R5: flag edges only at their defined positions
  a_r5_vbl_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(vblank_q) |-> (line_q == SET_LN && dot_q == F_DOT));
  a_r5_vbl_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(vblank_q) |-> (line_q == PRE_LN && dot_q == F_DOT));
  // R6: NMI is a single cycle and only with the flag up
  a_r6_nmi_single: assert property (@(posedge clk) disable iff (rst)
    nmi_q |=> !nmi_q);
  a_r6_nmi_with_flag: assert property (@(posedge clk) disable iff (rst)
    nmi_q |-> vblank_q);
  // R7: strobe stays inside the sprite window
  a_r7_oam_window: assert property (@(posedge clk) disable iff (rst)
    oam_clr_q |-> (dot_q >= W_LO && dot_q <= W_HI && region_q != RGN_VBLANK && region_q != RGN_POST));
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_pkg::*;
#(
  parameter int DOTS      = 341,
  parameter int LINES     = 262,
  parameter int VIS_LINES = 240,
  parameter int VBL_LINE  = 241,
  parameter int FLAG_DOT  = 1,
  parameter int OAM_LO    = 257,
  parameter int OAM_HI    = 320,
  parameter int FRAME_W   = 16,
  localparam int DOT_W    = $clog2(DOTS),
  localparam int LINE_W   = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               render_en,
  input  logic               nmi_en,
  output logic [DOT_W-1:0]   dot,
  output logic [LINE_W-1:0]  line,
  output logic               odd_frame,
  output logic [FRAME_W-1:0] frame_cnt,
  output logic [1:0]         region,
  output logic               vblank,
  output logic               nmi_pulse,
  output logic               oam_clr
);
  logic [DOT_W-1:0]  nxt_dot;
  logic [LINE_W-1:0] nxt_line;
  region_t           nxt_region, region_q;

  raster_pos_counter #(.DOTS(DOTS), .LINES(LINES), .FRAME_W(FRAME_W)) u_pos (
    .clk(clk), .rst(rst), .skip_en(render_en),
    .dot_q(dot), .line_q(line), .odd_q(odd_frame), .frame_q(frame_cnt),
    .nxt_dot(nxt_dot), .nxt_line(nxt_line)
  );

  raster_region #(.LINES(LINES), .VIS_LINES(VIS_LINES), .VBL_LINE(VBL_LINE)) u_rgn (
    .line_i(nxt_line), .region_o(nxt_region)
  );

  raster_events #(.DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL_LINE), .FLAG_DOT(FLAG_DOT),
                  .OAM_LO(OAM_LO), .OAM_HI(OAM_HI)) u_evt (
    .clk(clk), .rst(rst), .nmi_en(nmi_en),
    .nxt_dot(nxt_dot), .nxt_line(nxt_line), .nxt_region(nxt_region),
    .dot_q(dot), .line_q(line),
    .region_q(region_q), .vblank_q(vblank), .nmi_q(nmi_pulse), .oam_clr_q(oam_clr)
  );

  assign region = region_q;
endmodule

// File: tb/raster_timer_tb.sv
module raster_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DOTS = 341;
  localparam int LINES = 262;
  localparam int RUN_CYCLES = 89342 + 89341 + 400;
  localparam int WATCHDOG = 199000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic render_en = 1'b0;
  logic nmi_en = 1'b0;
  logic [8:0]  dot, line;
  logic        odd_frame, vblank, nmi_pulse, oam_clr;
  logic [15:0] frame_cnt;
  logic [1:0]  region;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  int m_dot, m_line, m_cnt;
  bit m_odd, m_vbl, m_nmi, m_oam;
  bit skipped;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timer u_dut (
    .clk(clk), .rst(rst), .render_en(render_en), .nmi_en(nmi_en),
    .dot(dot), .line(line), .odd_frame(odd_frame), .frame_cnt(frame_cnt),
    .region(region), .vblank(vblank), .nmi_pulse(nmi_pulse), .oam_clr(oam_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at line %0d dot %0d: actual=%0d expected=%0d", req, m_line, m_dot, act, exp);
    end
  endtask

  function automatic int exp_region(input int ln);
    if (ln < 240) return 0;        // R8 visible
    if (ln == 261) return 3;       // R8 pre-render
    if (ln == 240) return 1;       // R8 post-render
    return 2;                      // R8 vblank
  endfunction

  function automatic bit exp_oam(input int ln, input int d);
    return (ln < 240 || ln == 261) && d >= 257 && d <= 320;  // R7
  endfunction

  task automatic model_step(input bit ren, input bit nen);
    bit short_ln;
    short_ln = ren && m_odd && m_line == LINES-1 && m_dot == DOTS-2;  // R4
    skipped = short_ln;
    if (m_dot == DOTS-1 || short_ln) begin
      m_dot = 0;
      if (m_line == LINES-1) begin
        m_line = 0;
        m_odd = !m_odd;
        m_cnt = (m_cnt + 1) & 16'hffff;
      end else m_line++;
    end else m_dot++;
    m_nmi = (m_line == 241 && m_dot == 1) && nen;
    if (m_line == 241 && m_dot == 1) m_vbl = 1'b1;
    else if (m_line == 261 && m_dot == 1) m_vbl = 1'b0;
    m_oam = exp_oam(m_line, m_dot);
  endtask

  task automatic check_all();
    chk("R2 dot", int'(dot), m_dot);
    chk("R2 line", int'(line), m_line);
    chk("R3 odd_frame", int'(odd_frame), int'(m_odd));
    chk("R3 frame_cnt", int'(frame_cnt), m_cnt);
    chk("R8 region", int'(region), exp_region(m_line));
    chk("R5 vblank", int'(vblank), int'(m_vbl));
    chk("R6 nmi_pulse", int'(nmi_pulse), int'(m_nmi));
    chk("R7 oam_clr", int'(oam_clr), int'(m_oam));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= WATCHDOG) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_dot = 0; m_line = 0; m_cnt = 0; m_odd = 0;
    m_vbl = 0; m_nmi = 0; m_oam = 0; skipped = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    chk("R1 dot", int'(dot), 0);
    chk("R1 line", int'(line), 0);
    chk("R1 vblank", int'(vblank), 0);
    chk("R1 nmi_pulse", int'(nmi_pulse), 0);
    chk("R1 oam_clr", int'(oam_clr), 0);
    chk("R1 odd_frame", int'(odd_frame), 0);
    chk("R1 frame_cnt", int'(frame_cnt), 0);
    rst = 1'b0;
    for (int i = 0; i < RUN_CYCLES; i++) begin
      bit ren, nen;
      ren = 1'($urandom);
      nen = 1'($urandom);
      // R4: keep rendering on around the end of each frame (even: full line, odd: skip)
      if (m_line == LINES-1 && m_dot >= DOTS-12) ren = 1'b1;
      // R6: enabled in frame 0, disabled in frame 1 when entering the flag dot
      if (m_line == 241 && m_dot == 0) nen = (m_cnt == 0);
      render_en = ren;
      nmi_en = nen;
      @(posedge clk);
      model_step(ren, nen);
      @(negedge clk);
      check_all();
      if (skipped) chk("R4 skip lands on dot 0", int'(dot), 0);
      if (m_line == 261 && m_dot == 340) chk("R4 even frame keeps dot 340", int'(odd_frame), 0);
      if (m_line == 241 && m_dot == 1) chk("R6 flag set regardless of nmi_en", int'(vblank), 1);
    end
    chk("R3 two frames counted", int'(frame_cnt), 2);
    finish_run();
  end
endmodule